// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block chooses which of eight interrupt request lines is presented to the processor. It does not use a fixed order by line number. The order is a ring whose start can be moved. A 3-bit pointer names the line with the lowest priority. The line just after it on the ring has the highest priority, and the scan wraps from line 7 back to line 0. The block receives the request, mask and in-service vectors, the pointer and a special-mask-mode flag from the controller around it. It returns a registered interrupt request and the number of the winning line.

In normal mode the in-service vector bounds which lines may be raised: a request is raised only if it comes before every line already in service. In special-mask mode the in-service lines are skipped one by one and every other line remains eligible. Once the interrupt request is raised, it and the latched line number are frozen until the processor acknowledges. Evaluation resumes in the cycle after the acknowledge.

Top module: `rot_prio_resolver`

## Requirements
- R1: The highest-priority position is (lowest_i + 1) mod 8, and scanning advances by one with wrap from 7 to 0. When no interrupt is pending, the first eligible line on this ring is latched into line_o and int_o is high on the following clock.
- R2: A line is a candidate only when its req_i bit is 1 and its mask_i bit is 0. With no candidate, int_o stays low and line_o keeps its value.
- R3: While int_o is high and ack_i is low, int_o stays high and line_o does not change, whatever the other inputs do.
- R4: ack_i high while int_o is high drives int_o low on the next clock and leaves line_o unchanged. ack_i has no effect while int_o is low.
- R5: In normal mode (spec_mask_i = 0), if the in-service bit at the highest-priority position is set, int_o is not raised.
- R6: In normal mode, only candidates that come strictly before the first set in-service bit in ring order are eligible.
- R7: In normal mode with in-service all zero, all eight lines are eligible in ring order.
- R8: In special-mask mode (spec_mask_i = 1), all eight positions are scanned in ring order and any line whose in-service bit is set is skipped.
- R9: After reset, int_o is 0 and line_o is 0.
- R10: line_o changes only in the clock where int_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request vector, bit n for line n |
| mask_i | input | 8 | Mask vector, 1 blocks line n |
| insvc_i | input | 8 | In-service vector, bit n for line n |
| lowest_i | input | 3 | Number of the lowest-priority line |
| spec_mask_i | input | 1 | 1 selects special-mask mode |
| ack_i | input | 1 | Processor acknowledge of the pending request |
| int_o | output | 1 | Registered interrupt request |
| line_o | output | 3 | Latched number of the winning line |

## Verification
The bench builds the block with its default width of eight lines and a 3-bit pointer. With these values every one of the eight ring starting points can be driven, including the wrap from line 7 to line 0. The same width also covers every position of the first in-service bit relative to the ring start. Random request, mask and in-service vectors with varied pointers and modes are run against a behavioural scan model on every clock. Directed cases cover the wrap, a blocked top position, the special-mask skip and holding while a request is pending.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    parameter int RPR_LINES = 8;
    parameter int RPR_IDX_W = $clog2(RPR_LINES);

    typedef struct packed {
        logic                 irq;
        logic [RPR_IDX_W-1:0] line;
    } rpr_state_t;
endpackage

// File: rtl/rpr_rotate.sv
module rpr_rotate #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] start_i,
    output logic [N-1:0]  rot_o
);
    // rot_o[k] is the bit found k steps after start_i on the ring
    for (genvar k = 0; k < N; k++) begin : g_rot
        logic [IW-1:0] src;
        assign src      = start_i + IW'(k);
        assign rot_o[k] = vec_i[src];
    end
endmodule

// File: rtl/rpr_first.sv
module rpr_first #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] pos_o
);
    always_comb begin
        found_o = |vec_i;
        pos_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) pos_o = IW'(i);
        end
    end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
    import rpr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RPR_LINES-1:0] req_i,
    input  logic [RPR_LINES-1:0] mask_i,
    input  logic [RPR_LINES-1:0] insvc_i,
    input  logic [RPR_IDX_W-1:0] lowest_i,
    input  logic                 spec_mask_i,
    input  logic                 ack_i,
    output logic                 int_o,
    output logic [RPR_IDX_W-1:0] line_o
);
    localparam int N  = RPR_LINES;
    localparam int IW = RPR_IDX_W;

    rpr_state_t state_d, state_q;

    logic [IW-1:0] top_pos;
    logic [N-1:0]  cand_w, rot_cand, rot_isr, allow, elig;
    logic          isr_found, win_found;
    logic [IW-1:0] isr_pos, win_pos, win_line;

    assign top_pos = lowest_i + IW'(1);
    assign cand_w  = req_i & ~mask_i;

    rpr_rotate #(.N(N), .IW(IW)) u_rot_cand (
        .vec_i(cand_w), .start_i(top_pos), .rot_o(rot_cand));
    rpr_rotate #(.N(N), .IW(IW)) u_rot_isr (
        .vec_i(insvc_i), .start_i(top_pos), .rot_o(rot_isr));
    rpr_first #(.N(N), .IW(IW)) u_first_isr (
        .vec_i(rot_isr), .found_o(isr_found), .pos_o(isr_pos));

    // Eligibility per ring position: special mode skips in-service lines,
    // normal mode stops at the first in-service line.
    for (genvar k = 0; k < N; k++) begin : g_allow
        assign allow[k] = spec_mask_i ? ~rot_isr[k]
                                      : (~isr_found | (IW'(k) < isr_pos));
    end

    assign elig = rot_cand & allow;

    rpr_first #(.N(N), .IW(IW)) u_first_win (
        .vec_i(elig), .found_o(win_found), .pos_o(win_pos));

    assign win_line = top_pos + win_pos;

    always_comb begin
        state_d = state_q;
        if (state_q.irq) begin
            if (ack_i) state_d.irq = 1'b0;
        end else if (win_found) begin
            state_d.irq  = 1'b1;
            state_d.line = win_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign int_o  = state_q.irq;
    assign line_o = state_q.line;

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && !ack_i) |=> (int_o && $stable(line_o))); // R3
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && ack_i) |=> (!int_o && $stable(line_o))); // R4
    AST_LINE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(int_o) |-> $stable(line_o)); // R10
    AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |-> ((($past(cand_w) >> line_o) & N'(1)) != '0)); // R2
    AST_TOP_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_o && !spec_mask_i && insvc_i[top_pos]) |=> !int_o); // R5
    AST_SPEC_SKIPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_o) && $past(spec_mask_i)) |->
        ((($past(insvc_i) >> line_o) & N'(1)) == '0)); // R8
endmodule

// File: tb/rot_prio_resolver_tb.sv
`timescale 1ns/100ps
module rot_prio_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, mask = '0, isr = '0;
    logic [2:0] low = 3'd7;
    logic       spec = 1'b0, ack = 1'b0;
    logic       int_w;
    logic [2:0] line_w;

    int total = 0, bad = 0;
    bit m_int = 0;
    int m_line = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rot_prio_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(isr),
        .lowest_i(low), .spec_mask_i(spec), .ack_i(ack),
        .int_o(int_w), .line_o(line_w));

    task automatic check(input string tag);
        total++;
        if (int_w !== m_int || int'(line_w) != m_line) begin
            bad++;
            $display("FAIL %s: int=%0b line=%0d expected int=%0b line=%0d",
                     tag, int_w, line_w, m_int, m_line);
        end
    endtask

    // Behavioural model of one clock, then compare after the edge
    task automatic step(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s,
                        input logic [2:0] lo, input logic sp, input logic ak,
                        input string tag);
        bit n_int;
        int n_line, hi, stop, l;
        req = r; mask = m; isr = s; low = lo; spec = sp; ack = ak;
        n_int = m_int; n_line = m_line;
        if (m_int) begin
            if (ak) n_int = 0;
        end else begin
            hi = (lo + 1) % 8;
            stop = 8;
            if (!sp)
                for (int i = 0; i < 8; i++)
                    if (s[(hi + i) % 8]) begin stop = i; break; end
            for (int i = 0; i < stop; i++) begin
                l = (hi + i) % 8;
                if (r[l] && !m[l] && !(sp && s[l])) begin
                    n_int = 1; n_line = l; break;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_int = n_int; m_line = n_line;
        check(tag);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: int=%0b line=%0d expected run end", int_w, line_w);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9");
        // R1 R7: default ring, line 0 first
        step(8'h81, 8'h00, 8'h00, 3'd7, 0, 0, "R1");
        step(8'h00, 8'h00, 8'h00, 3'd7, 0, 1, "R4");
        // R1: pointer 3, line 4 leads over line 0
        step(8'h11, 8'h00, 8'h00, 3'd3, 0, 0, "R1");
        step(8'h00, 8'h00, 8'h00, 3'd3, 0, 1, "R4");
        // R1: wrap past 7 to 0
        step(8'h03, 8'h00, 8'h00, 3'd6, 0, 0, "R1");
        step(8'h00, 8'h00, 8'h00, 3'd6, 0, 1, "R4");
        // R2: masked lines ignored, none left means no INT
        step(8'hFF, 8'h0F, 8'h00, 3'd7, 0, 0, "R2");
        step(8'h00, 8'h00, 8'h00, 3'd7, 0, 1, "R4");
        step(8'h0F, 8'h0F, 8'h00, 3'd7, 0, 0, "R2");
        step(8'h00, 8'h00, 8'h00, 3'd7, 0, 1, "R4");
        // R5: top position in service blocks all
        step(8'hFE, 8'h00, 8'h01, 3'd7, 0, 0, "R5");
        step(8'hFF, 8'h00, 8'h20, 3'd4, 0, 0, "R5");
        // R6: only lines ahead of in-service line 3
        step(8'hF0, 8'h00, 8'h08, 3'd7, 0, 0, "R6");
        step(8'hF4, 8'h00, 8'h08, 3'd7, 0, 0, "R6");
        step(8'h00, 8'h00, 8'h00, 3'd7, 0, 1, "R4");
        // R8: special mask skips line 3, takes line 6
        step(8'h48, 8'h00, 8'h08, 3'd7, 1, 0, "R8");
        step(8'h00, 8'h00, 8'h00, 3'd7, 0, 1, "R4");
        // R3 R10: hold while pending
        step(8'h20, 8'h00, 8'h00, 3'd7, 0, 0, "R10");
        step(8'h01, 8'h00, 8'h00, 3'd7, 0, 0, "R3");
        step(8'h02, 8'h00, 8'h00, 3'd0, 1, 0, "R3");
        step(8'h02, 8'h00, 8'h00, 3'd0, 0, 1, "R4");
        // R4: ack while idle ignored
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 1, "R4");
        step(8'h04, 8'h00, 8'h00, 3'd0, 0, 1, "R4");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 1, "R4");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] r, m, s;
            logic sp, ak;
            string tg;
            r = 8'($urandom);
            m = 8'($urandom) & 8'($urandom);
            s = 8'($urandom) & 8'($urandom) & 8'($urandom);
            sp = ($urandom % 4) == 0;
            ak = ($urandom % 3) == 0;
            tg = m_int ? (ak ? "R4" : "R3") : (sp ? "R8" : (s == 0 ? "R7" : "R6"));
            step(r, m, s, 3'($urandom), sp, ak, tg);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule